// File: doc/BRIEF.md
# Accumulator-versus-Memory Scan Sequencer

This block walks through memory one byte at a time and compares each byte with an accumulator value. A 16-bit pointer moves by one after every byte, upward or downward as chosen at start. A 16-bit count goes down by one per byte. The block either performs a single step or keeps stepping until it finds a matching byte or the count reaches zero. After each step it publishes a flag byte that describes the comparison and the state of the count.

The surrounding core pulses a start input and supplies the initial pointer, count, accumulator and incoming carry. The block then drives a read port, holds each request until memory answers with a valid strobe, and reports the end of the sequence with a one-cycle done pulse. The final pointer, count and flags are on its outputs at that moment. Memory itself lives outside the block.

Top module: `mem_scan_cmp`

## Requirements
- R1: Each step consumes exactly one memory byte, read at the current pointer. After the step the count is one less than before, modulo 2^16, so a start count of 0 becomes 0xFFFF after the first step.
- R2: After each step the pointer is one higher when dirDown is 0 and one lower when dirDown is 1, modulo 2^16.
- R3: In the flag byte, bit 0 (carry) equals the carryIn value captured at start, and bit 1 (subtract) is 1 after every step.
- R4: Flag bit 6 (zero) is 1 exactly when the accumulator equals the byte read in the latest step.
- R5: Flag bit 2 (count state) is 1 when the count after the decrement is nonzero and 0 when it is zero.
- R6: Flag bit 7 is bit 7 of (accumulator minus byte) modulo 256. Bit 4 is the borrow out of the low nibble, that is, accumulator[3:0] < byte[3:0]. Bits 5 and 3 are 0.
- R7: With repeatEn at 0, a start performs exactly one step and then ends.
- R8: With repeatEn at 1, steps continue until the zero flag becomes 1 or the count reaches zero. The outputs then hold the results of the stopping step.
- R9: memReq stays high with a stable memAddr until memValid is seen, for any memory latency. memAddr is the current pointer.
- R10: done is high for exactly one cycle, in the cycle after the final memory handshake, with the final pointer, count and flags already on the outputs.
- R11: A start pulse while busy is high has no effect on the running sequence or its results.
- R12: After reset, memReq, busy and done are 0, and addrOut, countOut and flagsOut are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Starts a sequence when the block is idle |
| dirDown | input | 1 | 0 moves the pointer upward, 1 moves it downward |
| repeatEn | input | 1 | 1 repeats until a stop condition, 0 runs a single step |
| addrInit | input | 16 | Initial pointer |
| countInit | input | 16 | Initial count |
| accVal | input | 8 | Accumulator value to compare |
| carryIn | input | 1 | Incoming carry, passed through to the flag byte |
| memReq | output | 1 | Read request |
| memAddr | output | 16 | Read address |
| memData | input | 8 | Read data, valid with memValid |
| memValid | input | 1 | Read data strobe |
| addrOut | output | 16 | Current pointer |
| countOut | output | 16 | Current count |
| flagsOut | output | 8 | Flag byte from the latest step |
| done | output | 1 | One-cycle end-of-sequence pulse |
| busy | output | 1 | High while a sequence is running |

## Verification
A stale or wrong pointer appears on memAddr in the very next request. It also shows as a wrong byte being compared, which changes the zero, sign and half-borrow flags one cycle after that handshake. A count that is off by one changes the count-state flag and, in repeat mode, the number of handshakes before done. The bench can see that difference when done arrives. A control state that fails to return to idle shows up as a missing done pulse, a done longer than one cycle, or a start that is ignored, and the watchdog catches a hang.

// File: rtl/mem_scan_pkg.sv
package mem_scan_pkg;

  localparam int FLAG_W  = 8;
  localparam int FLAG_C  = 0;
  localparam int FLAG_N  = 1;
  localparam int FLAG_PV = 2;
  localparam int FLAG_H  = 4;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_S  = 7;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } scanState_t;

  typedef struct packed {
    logic load;
    logic step;
  } scanStrobe_t;

endpackage

// File: rtl/mem_scan_ctrl.sv
module mem_scan_ctrl
  import mem_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        memValid,
  input  logic        stepFinal,
  output scanStrobe_t strobe,
  output logic        busy,
  output logic        memReq,
  output logic        done
);

  scanState_t state;
  logic       doneReg;

  always_comb begin
    strobe.load = (state == ST_IDLE) && startReq;
    strobe.step = (state == ST_FETCH) && memValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startReq) state <= ST_FETCH;
        end
        ST_FETCH: begin
          if (memValid && stepFinal) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state == ST_FETCH);
  assign memReq = busy;
  assign done   = doneReg;

endmodule

// File: rtl/mem_scan_dp.sv
module mem_scan_dp
  import mem_scan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  scanStrobe_t         strobe,
  input  logic                dirDown,
  input  logic                repeatEn,
  input  logic [ADDR_W-1:0]   addrInit,
  input  logic [CNT_W-1:0]    countInit,
  input  logic [DATA_W-1:0]   accVal,
  input  logic                carryIn,
  input  logic [DATA_W-1:0]   memData,
  output logic                stepFinal,
  output logic [ADDR_W-1:0]   addrOut,
  output logic [CNT_W-1:0]    countOut,
  output logic [FLAG_W-1:0]   flagsOut
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  cntReg;
  logic [DATA_W-1:0] accReg;
  logic              carryReg;
  logic              dirReg;
  logic              repReg;
  logic [FLAG_W-1:0] flagReg;

  logic [DATA_W-1:0] diff;
  logic              halfBorrow;
  logic              hit;
  logic [CNT_W-1:0]  cntNext;
  logic [ADDR_W-1:0] addrNext;
  logic [FLAG_W-1:0] flagNext;

  always_comb begin
    diff       = accReg - memData;
    halfBorrow = accReg[HALF_W-1:0] < memData[HALF_W-1:0];
    hit        = (accReg == memData);
    cntNext    = cntReg - CNT_ONE;
    addrNext   = dirReg ? (addrReg - ADDR_ONE) : (addrReg + ADDR_ONE);
    stepFinal  = !repReg || (cntNext == '0) || hit;
    flagNext          = '0;
    flagNext[FLAG_S]  = diff[DATA_W-1];
    flagNext[FLAG_Z]  = hit;
    flagNext[FLAG_H]  = halfBorrow;
    flagNext[FLAG_PV] = (cntNext != '0);
    flagNext[FLAG_N]  = 1'b1;
    flagNext[FLAG_C]  = carryReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      cntReg   <= '0;
      accReg   <= '0;
      carryReg <= 1'b0;
      dirReg   <= 1'b0;
      repReg   <= 1'b0;
      flagReg  <= '0;
    end else if (strobe.load) begin
      addrReg  <= addrInit;
      cntReg   <= countInit;
      accReg   <= accVal;
      carryReg <= carryIn;
      dirReg   <= dirDown;
      repReg   <= repeatEn;
    end else if (strobe.step) begin
      addrReg <= addrNext;
      cntReg  <= cntNext;
      flagReg <= flagNext;
    end
  end

  assign addrOut  = addrReg;
  assign countOut = cntReg;
  assign flagsOut = flagReg;

endmodule

// File: rtl/mem_scan_cmp.sv
module mem_scan_cmp
  import mem_scan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              dirDown,
  input  logic              repeatEn,
  input  logic [ADDR_W-1:0] addrInit,
  input  logic [CNT_W-1:0]  countInit,
  input  logic [DATA_W-1:0] accVal,
  input  logic              carryIn,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  input  logic              memValid,
  output logic [ADDR_W-1:0] addrOut,
  output logic [CNT_W-1:0]  countOut,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              done,
  output logic              busy
);

  scanStrobe_t strobe;
  logic        stepFinal;

  mem_scan_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .memValid  (memValid),
    .stepFinal (stepFinal),
    .strobe    (strobe),
    .busy      (busy),
    .memReq    (memReq),
    .done      (done)
  );

  mem_scan_dp #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dirDown   (dirDown),
    .repeatEn  (repeatEn),
    .addrInit  (addrInit),
    .countInit (countInit),
    .accVal    (accVal),
    .carryIn   (carryIn),
    .memData   (memData),
    .stepFinal (stepFinal),
    .addrOut   (addrOut),
    .countOut  (countOut),
    .flagsOut  (flagsOut)
  );

  assign memAddr = addrOut;

endmodule

// File: rtl/mem_scan_chk.sv
module mem_scan_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              dirDown,
  input logic              carryIn,
  input logic [DATA_W-1:0] accVal,
  input logic              memReq,
  input logic              memValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData,
  input logic [ADDR_W-1:0] addrOut,
  input logic [CNT_W-1:0]  countOut,
  input logic [7:0]        flagsOut,
  input logic              done,
  input logic              busy
);

  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

  logic              dirSeen;
  logic              carrySeen;
  logic [DATA_W-1:0] accSeen;
  logic [DATA_W-1:0] diffSeen;
  logic              handshake;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirSeen   <= 1'b0;
      carrySeen <= 1'b0;
      accSeen   <= '0;
    end else if (startReq && !busy) begin
      dirSeen   <= dirDown;
      carrySeen <= carryIn;
      accSeen   <= accVal;
    end
  end

  always_comb begin
    handshake = memReq && memValid;
    diffSeen  = accSeen - memData;
  end

  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rstN)
    handshake |=> countOut == $past(countOut) - C_ONE); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    handshake |=> addrOut == (dirSeen ? $past(memAddr) - A_ONE : $past(memAddr) + A_ONE)); // R2
  AST_CARRY_SUB: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (flagsOut[0] == carrySeen) && flagsOut[1]); // R3
  AST_ZERO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    handshake |=> flagsOut[6] == (accSeen == $past(memData))); // R4
  AST_PV_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> flagsOut[2] == (countOut != '0)); // R5
  AST_SIGN_HALF: assert property (@(posedge clk) disable iff (!rstN)
    handshake |=> (flagsOut[7] == $past(diffSeen[DATA_W-1])) &&
                  (flagsOut[4] == ($past(accSeen[3:0]) < $past(memData[3:0]))) &&
                  !flagsOut[5] && !flagsOut[3]); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq && $past(handshake)); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy && !handshake |=> busy && $stable(countOut)); // R11

endmodule

bind mem_scan_cmp mem_scan_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .dirDown  (dirDown),
  .carryIn  (carryIn),
  .accVal   (accVal),
  .memReq   (memReq),
  .memValid (memValid),
  .memAddr  (memAddr),
  .memData  (memData),
  .addrOut  (addrOut),
  .countOut (countOut),
  .flagsOut (flagsOut),
  .done     (done),
  .busy     (busy)
);

// File: tb/mem_scan_cmp_tb_top.sv
module mem_scan_cmp_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        dirDown = 1'b0;
  logic        repeatEn = 1'b0;
  logic [15:0] addrInit = '0;
  logic [15:0] countInit = '0;
  logic [7:0]  accVal = '0;
  logic        carryIn = 1'b0;
  logic        memReq;
  logic [15:0] memAddr;
  logic [7:0]  memData = '0;
  logic        memValid = 1'b0;
  logic [15:0] addrOut;
  logic [15:0] countOut;
  logic [7:0]  flagsOut;
  logic        done;
  logic        busy;

  int total = 0;
  int bad = 0;
  int hsTotal = 0;
  int maxLat = 3;
  int waitCnt = 0;
  bit finished = 0;
  logic [7:0] mem [256];

  always #10 clk = ~clk;

  mem_scan_cmp dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dirDown(dirDown),
    .repeatEn(repeatEn), .addrInit(addrInit), .countInit(countInit),
    .accVal(accVal), .carryIn(carryIn), .memReq(memReq), .memAddr(memAddr),
    .memData(memData), .memValid(memValid), .addrOut(addrOut),
    .countOut(countOut), .flagsOut(flagsOut), .done(done), .busy(busy)
  );

  always @(posedge clk) if (memReq && memValid) hsTotal <= hsTotal + 1;

  initial begin
    forever begin
      @(negedge clk);
      memValid = 1'b0;
      if (memReq) begin
        if (waitCnt == 0) begin
          memValid = 1'b1;
          memData  = mem[memAddr[7:0]];
          waitCnt  = (maxLat == 0) ? 0 : int'($urandom % (maxLat + 1));
        end else begin
          waitCnt = waitCnt - 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] a0, input logic [15:0] n0, input logic [7:0] acc,
                       input logic cin, input logic dn, input logic rp,
                       output logic [15:0] ea, output logic [15:0] ec,
                       output logic [7:0] ef, output int es);
    logic [7:0] b;
    logic [7:0] d;
    bit z;
    bit stop;
    ea = a0; ec = n0; es = 0; ef = '0;
    do begin
      b = mem[ea[7:0]];
      d = acc - b;
      z = (acc == b);
      ec = ec - 16'd1;
      ea = dn ? ea - 16'd1 : ea + 16'd1;
      es++;
      ef = {d[7], z, 1'b0, (acc[3:0] < b[3:0]), 1'b0, (ec != 0), 1'b1, cin};
      stop = !rp || (ec == 0) || z;
    end while (!stop);
  endtask

  task automatic runScan(input logic [15:0] a0, input logic [15:0] n0, input logic [7:0] acc,
                         input logic cin, input logic dn, input logic rp, input bit poke);
    logic [15:0] ea, ec;
    logic [7:0] ef;
    int es, hs0, steps;
    model(a0, n0, acc, cin, dn, rp, ea, ec, ef, es);
    @(negedge clk);
    hs0 = hsTotal;
    startReq = 1; addrInit = a0; countInit = n0; accVal = acc; carryIn = cin;
    dirDown = dn; repeatEn = rp;
    @(negedge clk);
    startReq = 0;
    if (poke) begin
      repeat (2) @(negedge clk);
      startReq = 1; addrInit = ~a0; countInit = 16'd1; accVal = ~acc;
      carryIn = ~cin; dirDown = ~dn; repeatEn = 0;
      @(negedge clk);
      startReq = 0;
    end
    while (!done) @(negedge clk);
    steps = hsTotal - hs0;
    check(addrOut == ea, poke ? "R11 addr" : "R2 addr", addrOut, ea);
    check(countOut == ec, "R1 count", countOut, ec);
    check(flagsOut[1:0] == ef[1:0], "R3 carry/sub", flagsOut, ef);
    check(flagsOut[6] == ef[6], "R4 zero", flagsOut, ef);
    check(flagsOut[2] == ef[2], "R5 count-state", flagsOut, ef);
    check({flagsOut[7:3]} == {ef[7:3]}, "R6 sign/half", flagsOut, ef);
    check(steps == es, rp ? "R8 steps" : "R7 steps", steps, es);
    @(negedge clk);
    check(done == 1'b0, "R10 done width", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R12 reset state
    check({memReq, busy, done} == 3'b0, "R12 control", {memReq, busy, done}, 0);
    check({addrOut, countOut, flagsOut} == '0, "R12 data", {addrOut, countOut}, 0);

    // R7 single step upward and downward, borrow patterns
    mem[8'h10] = 8'h3F;
    runScan(16'h0010, 16'd5, 8'h20, 1'b1, 1'b0, 1'b0, 0);
    mem[8'h10] = 8'h20;
    runScan(16'h0010, 16'd5, 8'h20, 1'b0, 1'b1, 1'b0, 0);
    // R1 count 0 wraps to 0xFFFF, count-state stays 1
    runScan(16'h1234, 16'd0, 8'h00, 1'b1, 1'b0, 1'b0, 0);
    // R2 pointer wrap both ways
    runScan(16'hFFFF, 16'd3, 8'h77, 1'b0, 1'b0, 1'b0, 0);
    runScan(16'h0000, 16'd3, 8'h77, 1'b0, 1'b1, 1'b0, 0);

    // R8 repeat until count exhausted, value absent from memory
    v = 8'hC3;
    for (int i = 0; i < 256; i++) if (mem[i] == v) mem[i] = v + 8'd1;
    runScan(16'h0040, 16'd12, v, 1'b1, 1'b0, 1'b1, 0);
    runScan(16'h0001, 16'd1, v, 1'b0, 1'b1, 1'b1, 0);
    // R8 repeat stops on a match planted at the fourth byte
    mem[8'h53] = v;
    runScan(16'h0050, 16'd20, v, 1'b0, 1'b0, 1'b1, 0);
    mem[8'h4D] = v;
    runScan(16'h0050, 16'd20, v, 1'b1, 1'b1, 1'b1, 0);
    mem[8'h53] = v + 8'd1; mem[8'h4D] = v + 8'd1;

    // R11 start pulse while busy is ignored
    runScan(16'h0080, 16'd10, v, 1'b1, 1'b0, 1'b1, 1);

    // R9 long memory latency
    maxLat = 9;
    runScan(16'h00A0, 16'd6, v, 1'b0, 1'b1, 1'b1, 0);
    maxLat = 0;
    runScan(16'h00B0, 16'd6, v, 1'b1, 1'b0, 1'b1, 0);
    maxLat = 3;

    // random mix, accumulator often taken from memory ahead of the pointer
    for (int k = 0; k < 40; k++) begin
      logic [15:0] a0;
      logic [7:0] acc;
      bit dn;
      a0 = 16'($urandom);
      dn = 1'($urandom);
      acc = ($urandom % 2) ? mem[8'(dn ? a0 - 16'($urandom % 8) : a0 + 16'($urandom % 8))]
                           : 8'($urandom);
      runScan(a0, 16'(1 + $urandom % 24), acc, 1'($urandom), dn, 1'($urandom), 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule